// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial channel that exchanges 8-bit frames over three lines: a transfer clock, a data output and a data input. There is no start bit, stop bit or parity bit. Software-side logic loads a transmit holding register with a write strobe and collects received bytes from a receive holding register with a read strobe. Both directions are clocked by the same transfer clock. The clock comes from one of two places: an internal divider, in which case the block drives the clock pin, or an external master on the clock input pin.

The transmitter owns every frame. A frame starts only when a transmit byte is waiting. Receive data is sampled during that same frame, so collecting data always needs the transmit side to be enabled and loaded. Several options shape the line format: clock polarity, bit order, and data inversion. The channel also has optional hardware flow control (a clear-to-send input and a ready-to-receive output). A continuous-receive mode re-sends the held transmit byte each time the receive register is read. Two single-cycle interrupt pulses report transmit and receive progress. A sticky flag reports receive overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After synchronous reset, with clk_pol low, these outputs are low: tx_irq, rx_irq, overrun and rd_data. sclk_o, sclk_oe and sdo are high.
- R2: In internal-clock mode each half period of sclk_o lasts div_n+1 cycles of clk. Between frames sclk_o rests at its idle level, which is high when clk_pol is 0 and low when clk_pol is 1.
- R3: A frame is exactly 8 data bits with no framing bits. With msb_first low, bit 0 goes out first, and the bit received first lands in bit 0 of rd_data.
- R4: With msb_first high, bit 7 goes out first, and the bit received first lands in bit 7 of rd_data.
- R5: With invert high, sdo carries the complement of each transmit bit, and every bit sampled from sdi is complemented before it is stored.
- R6: A frame starts only when all of these hold: tx_en is high, a transmit byte is waiting, and either cts_en is low or the synchronized cts_n is low. While any of these is missing, sclk_o does not toggle.
- R7: A frame sent while rx_en is low raises no rx_irq and leaves rd_data unchanged.
- R8: When txirq_on_done is 0, tx_irq pulses when the waiting byte moves into the shifter, before the first clock edge of the frame. When it is 1, tx_irq pulses after the last bit, in the same cycle as rx_irq.
- R9: When a received frame is stored into rd_data, rx_irq pulses for exactly one cycle.
- R10: overrun goes high if the 7th bit of a frame is sampled while the previous received byte is still unread. A read strobe on rd_rx clears overrun.
- R11: With cont_rx high, the transmit byte is kept after use, and a new frame does not start while a received byte is unread. A read strobe alone starts the next frame.
- R12: With rts_en high, rts_n is low while rx_en is high and no unread byte is held, and rts_n is high while an unread byte is held. With rts_en low, rts_n is driven low.
- R13: The data line changes on the leading edge of sclk (the edge away from idle) and is sampled on the trailing edge. With clk_pol 0 the leading edge is falling; with clk_pol 1 it is rising.
- R14: With ext_clk_sel high, sclk_oe is low and each frame is shifted by edges arriving on sclk_i, which is synchronized to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| ext_clk_sel | input | 1 | 1: transfer clock from sclk_i; 0: internal divider |
| clk_pol | input | 1 | Clock polarity (0: idle high, shift out on falling edge) |
| msb_first | input | 1 | Bit order select (1: bit 7 first) |
| invert | input | 1 | Complement data on both lines |
| cont_rx | input | 1 | Continuous-receive mode |
| txirq_on_done | input | 1 | tx_irq timing: 0 on buffer load, 1 on shift complete |
| cts_en | input | 1 | Honour the clear-to-send input |
| rts_en | input | 1 | Drive the ready-to-receive output |
| div_n | input | DIV_W | Divider setting n; half period is n+1 clk cycles |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | DATA_W | Transmit byte |
| rd_rx | input | 1 | Read strobe for the receive holding register |
| rd_data | output | DATA_W | Receive holding register |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Driven transfer clock |
| sclk_oe | output | 1 | Output enable for sclk_o |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
Most frames run with sdo looped back to sdi. Each byte is chosen so that a wrong bit order, a missing inversion or a swapped sampling edge gives a different value. The bench rebuilds the bit stream seen on sdo at every trailing clock edge and compares it with both plain and bit-reversed expectations. It also drives a fixed sdi level with inversion on, which keeps a loopback bug from masking a receive-side inversion fault. Frames are also run on an externally supplied clock with an independent sdi pattern. Other tests repeat frames without a read, to separate overrun and ready-to-receive behaviour. Gating tests hold back transmit enable or clear-to-send and count clock toggles to show that nothing started.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned DEF_DIV_W  = 8;

  typedef struct packed {
    logic msb_first;
    logic invert;
  } ssx_fmt_t;

endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= RST_VAL;
        else     ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             pol,
  input  logic [DIV_W-1:0] div_n,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             lead_ev,
  output logic             trail_ev
);

  localparam int unsigned HALF_EDGES = 2 * DATA_W;
  localparam int unsigned EDGE_W     = $clog2(HALF_EDGES + 1);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(HALF_EDGES);

  logic              idle_lvl;
  logic              sclk_s;
  logic              sclk_d;
  logic [DIV_W-1:0]  cnt;
  logic [EDGE_W-1:0] edges;
  logic              level;

  assign idle_lvl = ~pol;
  assign sclk_o   = level;

  ssx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      edges    <= '0;
      level    <= 1'b1;
      lead_ev  <= 1'b0;
      trail_ev <= 1'b0;
      sclk_d   <= 1'b1;
    end else begin
      lead_ev  <= 1'b0;
      trail_ev <= 1'b0;
      sclk_d   <= sclk_s;
      if (!run) begin
        cnt   <= '0;
        edges <= '0;
        level <= idle_lvl;
      end else if (ext_sel) begin
        if (sclk_s != sclk_d) begin
          lead_ev  <= (sclk_s != idle_lvl);
          trail_ev <= (sclk_s == idle_lvl);
        end
      end else if (edges != EDGE_LAST) begin
        if (cnt == div_n) begin
          cnt      <= '0;
          edges    <= edges + 1'b1;
          level    <= ~level;
          lead_ev  <= (level == idle_lvl);
          trail_ev <= (level != idle_lvl);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ssx_engine.sv
module ssx_engine
  import ssx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  ssx_fmt_t          fmt,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic              sdi,
  output logic              busy,
  output logic              sdo,
  output logic              samp_late,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LATE_IDX = BIT_W'(DATA_W - 2);

  logic [DATA_W-1:0] tsh;
  logic [BIT_W-1:0]  bitcnt;
  logic              in_bit;

  assign in_bit = sdi ^ fmt.invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sdo       <= 1'b1;
      samp_late <= 1'b0;
      done      <= 1'b0;
      tsh       <= '0;
      rx_word   <= '0;
      bitcnt    <= '0;
    end else begin
      samp_late <= 1'b0;
      done      <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        tsh    <= load_data;
        bitcnt <= '0;
      end else if (busy) begin
        if (lead_ev) begin
          if (fmt.msb_first) begin
            sdo <= tsh[DATA_W-1] ^ fmt.invert;
            tsh <= {tsh[DATA_W-2:0], 1'b0};
          end else begin
            sdo <= tsh[0] ^ fmt.invert;
            tsh <= {1'b0, tsh[DATA_W-1:1]};
          end
        end
        if (trail_ev) begin
          if (fmt.msb_first) rx_word <= {rx_word[DATA_W-2:0], in_bit};
          else               rx_word <= {in_bit, rx_word[DATA_W-1:1]};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LATE_IDX) samp_late <= 1'b1;
          if (bitcnt == LAST_IDX) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int unsigned DATA_W      = FRAME_BITS,
  parameter int unsigned DIV_W       = DEF_DIV_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              ext_clk_sel,
  input  logic              clk_pol,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              cont_rx,
  input  logic              txirq_on_done,
  input  logic              cts_en,
  input  logic              rts_en,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              wr_tx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_rx,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              overrun,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdo,
  input  logic              sdi,
  input  logic              cts_n,
  output logic              rts_n
);

  logic [DATA_W-1:0] tx_buf;
  logic              tx_full;
  logic              rx_full;
  logic              rx_on;
  logic              cts_s;
  logic              cts_ok;
  logic              start;
  logic              eng_busy;
  logic              eng_late;
  logic              eng_done;
  logic [DATA_W-1:0] eng_rx;
  logic              lead_ev;
  logic              trail_ev;
  logic              sclk_int;
  ssx_fmt_t          fmt;

  assign fmt.msb_first = msb_first;
  assign fmt.invert    = invert;

  ssx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst(rst), .d(cts_n), .q(cts_s)
  );

  assign cts_ok = !cts_en || !cts_s;
  assign start  = !eng_busy && !eng_done && tx_en && tx_full && cts_ok &&
                  (!cont_rx || (rx_en && !rx_full));

  ssx_clkgen #(.DIV_W(DIV_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst(rst), .run(eng_busy), .ext_sel(ext_clk_sel), .pol(clk_pol),
    .div_n(div_n), .sclk_i(sclk_i), .sclk_o(sclk_int),
    .lead_ev(lead_ev), .trail_ev(trail_ev)
  );

  ssx_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .load_data(tx_buf), .fmt(fmt),
    .lead_ev(lead_ev), .trail_ev(trail_ev), .sdi(sdi),
    .busy(eng_busy), .sdo(sdo), .samp_late(eng_late), .done(eng_done),
    .rx_word(eng_rx)
  );

  assign sclk_o  = sclk_int;
  assign sclk_oe = !ext_clk_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      rx_on   <= 1'b0;
      tx_irq  <= 1'b0;
    end else begin
      if (start) begin
        rx_on <= rx_en;
        if (!cont_rx) tx_full <= 1'b0;
      end
      if (wr_tx) begin
        tx_buf  <= wr_data;
        tx_full <= 1'b1;
      end
      tx_irq <= txirq_on_done ? eng_done : start;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      rx_irq  <= 1'b0;
      rts_n   <= 1'b1;
    end else begin
      if (rd_rx) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (eng_late && rx_on && rx_full) overrun <= 1'b1;
      if (eng_done && rx_on) begin
        rd_data <= eng_rx;
        rx_full <= 1'b1;
      end
      rx_irq <= eng_done && rx_on;
      rts_n  <= rts_en ? !(rx_en && !rx_full) : 1'b0;
    end
  end

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic rx_en,
  input logic cont_rx,
  input logic rts_en,
  input logic ext_clk_sel,
  input logic clk_pol,
  input logic sclk_o,
  input logic tx_irq,
  input logic rx_irq,
  input logic overrun,
  input logic rts_n,
  input logic busy,
  input logic tx_full,
  input logic rx_full
);

  // R2: the driven clock rests at its idle level whenever no frame runs
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !ext_clk_sel && $past(!ext_clk_sel) && $stable(clk_pol))
      |-> (sclk_o == !clk_pol));

  // R6: a frame only begins with transmit enabled and a byte waiting
  a_r6_start_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_en && tx_full));

  // R8: transmit interrupt is a single-cycle pulse
  a_r8_txirq_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  // R9: receive interrupt is a single-cycle pulse and marks a held byte
  a_r9_rxirq_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);
  a_r9_rxirq_full: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  // R10: overrun only rises while an unread byte is held
  a_r10_ovr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_full));

  // R11: continuous mode never starts a frame over an unread byte
  a_r11_cont_wait: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(cont_rx)) |-> $past(rx_en && !rx_full));

  // R12: ready-to-receive is withdrawn while a byte is held
  a_r12_rts_busy: assert property (@(posedge clk) disable iff (rst)
    (rts_en && $past(rts_en) && $past(rx_full)) |-> rts_n);

endmodule

bind sync_serial_xcvr ssx_checker u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .cont_rx(cont_rx),
  .rts_en(rts_en), .ext_clk_sel(ext_clk_sel), .clk_pol(clk_pol),
  .sclk_o(sclk_o), .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun),
  .rts_n(rts_n), .busy(eng_busy), .tx_full(tx_full), .rx_full(rx_full)
);

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b1, rx_en = 1'b1, ext_clk_sel = 1'b0, clk_pol = 1'b0;
  logic       msb_first = 1'b0, invert = 1'b0, cont_rx = 1'b0, txirq_on_done = 1'b0;
  logic       cts_en = 1'b0, rts_en = 1'b0;
  logic [7:0] div_n = 8'd1;
  logic       wr_tx = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_rx = 1'b0;
  logic [7:0] rd_data;
  logic       tx_irq, rx_irq, overrun;
  logic       sclk_i = 1'b1;
  logic       sclk_o, sclk_oe, sdo, rts_n;
  logic       cts_n = 1'b1;
  logic       loop_en = 1'b1;
  logic       sdi_drv = 1'b0;
  wire        sdi = loop_en ? sdo : sdi_drv;

  always #2 clk = ~clk;

  sync_serial_xcvr dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .ext_clk_sel(ext_clk_sel),
    .clk_pol(clk_pol), .msb_first(msb_first), .invert(invert), .cont_rx(cont_rx),
    .txirq_on_done(txirq_on_done), .cts_en(cts_en), .rts_en(rts_en), .div_n(div_n),
    .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rd_data(rd_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi), .cts_n(cts_n),
    .rts_n(rts_n)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int toggles = 0;
  int last_tog = 0;
  int half_len = 0;
  int rxirq_cnt = 0;
  logic [7:0] cap = 8'd0;
  logic prev_sclk = 1'b1;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // line monitor: clock toggles, half period, sdo at each trailing edge
  always @(negedge clk) begin
    prev_sclk <= sclk_o;
    if (!rst && sclk_o != prev_sclk) begin
      toggles  <= toggles + 1;
      half_len <= cyc - last_tog;
      last_tog <= cyc;
      if (sclk_o == !clk_pol) cap <= {sdo, cap[7:1]};
    end
    if (rx_irq) rxirq_cnt <= rxirq_cnt + 1;
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d; wr_tx = 1'b1;
    @(negedge clk);
    wr_tx = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_rx = 1'b1;
    @(negedge clk);
    rd_rx = 1'b0;
  endtask

  task automatic wait_rx(output bit seen, output bit tx_same);
    seen = 1'b0; tx_same = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (rx_irq) begin seen = 1'b1; tx_same = tx_irq; end
    end
  endtask

  task automatic wait_tx(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (tx_irq) seen = 1'b1;
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic t_reset();
    chk("R1 sclk_o", sclk_o, 1);
    chk("R1 sclk_oe", sclk_oe, 1);
    chk("R1 sdo", sdo, 1);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_divider();
    bit s, t;
    div_n = 8'd5;
    pulse_wr(8'hE1);
    wait_rx(s, t);
    chk("R2 half period", half_len, 6);
    idle(3);
    chk("R2 idle high", sclk_o, 1);
    pulse_rd();
    div_n = 8'd1;
  endtask

  task automatic t_lsb();
    bit s, t;
    int base;
    base = rxirq_cnt;
    pulse_wr(8'h3C);
    wait_rx(s, t);
    chk("R9 rx_irq seen", s, 1);
    chk("R3 rx byte", rd_data, 8'h3C);
    chk("R3 line order", cap, 8'h3C);
    idle(2);
    chk("R9 single pulse", rxirq_cnt - base, 1);
    pulse_rd();
  endtask

  task automatic t_msb();
    bit s, t;
    msb_first = 1'b1;
    pulse_wr(8'h0B);
    wait_rx(s, t);
    chk("R4 line order", cap, rev8(8'h0B));
    chk("R4 rx byte", rd_data, 8'h0B);
    pulse_rd();
    msb_first = 1'b0;
  endtask

  task automatic t_invert();
    bit s, t;
    invert = 1'b1;
    pulse_wr(8'h96);
    wait_rx(s, t);
    chk("R5 line complemented", cap, 8'h69);
    chk("R5 loop byte", rd_data, 8'h96);
    pulse_rd();
    loop_en = 1'b0; sdi_drv = 1'b0;
    pulse_wr(8'h5A);
    wait_rx(s, t);
    chk("R5 rx complemented", rd_data, 8'hFF);
    pulse_rd();
    loop_en = 1'b1; invert = 1'b0;
  endtask

  task automatic t_pol1();
    bit s, t;
    clk_pol = 1'b1;
    idle(3);
    chk("R2 idle low pol1", sclk_o, 0);
    pulse_wr(8'h5A);
    wait_rx(s, t);
    chk("R13 rx byte pol1", rd_data, 8'h5A);
    chk("R13 line pol1", cap, 8'h5A);
    pulse_rd();
    clk_pol = 1'b0;
    idle(3);
  endtask

  task automatic t_gate();
    bit s, t;
    int base;
    tx_en = 1'b0;
    pulse_wr(8'h33);
    base = toggles;
    idle(100);
    chk("R6 tx_en low", toggles - base, 0);
    cts_en = 1'b1; cts_n = 1'b1; tx_en = 1'b1;
    idle(100);
    chk("R6 cts high", toggles - base, 0);
    cts_n = 1'b0;
    wait_rx(s, t);
    chk("R6 cts low runs", s, 1);
    chk("R6 byte", rd_data, 8'h33);
    pulse_rd();
    cts_en = 1'b0; cts_n = 1'b1;
  endtask

  task automatic t_rx_dis();
    bit s;
    int base;
    logic [7:0] old;
    rx_en = 1'b0; txirq_on_done = 1'b1;
    old = rd_data; base = rxirq_cnt;
    pulse_wr(8'hC3);
    wait_tx(s);
    idle(4);
    chk("R7 frame sent", s, 1);
    chk("R7 no rx_irq", rxirq_cnt - base, 0);
    chk("R7 rd_data kept", rd_data, old);
    rx_en = 1'b1; txirq_on_done = 1'b0;
  endtask

  task automatic t_txirq();
    bit s, t;
    int base;
    base = toggles;
    pulse_wr(8'h21);
    wait_tx(s);
    chk("R8 load irq", s, 1);
    chk("R8 before first edge", toggles - base, 0);
    wait_rx(s, t);
    pulse_rd();
    txirq_on_done = 1'b1;
    pulse_wr(8'h42);
    wait_rx(s, t);
    chk("R8 done irq with rx_irq", t, 1);
    pulse_rd();
    txirq_on_done = 1'b0;
  endtask

  task automatic t_overrun();
    bit s, t;
    rts_en = 1'b1;
    idle(3);
    chk("R12 ready", rts_n, 0);
    pulse_wr(8'h11);
    wait_rx(s, t);
    idle(2);
    chk("R12 held", rts_n, 1);
    chk("R10 no overrun yet", overrun, 0);
    pulse_wr(8'h22);
    wait_rx(s, t);
    chk("R10 overrun set", overrun, 1);
    pulse_rd();
    idle(2);
    chk("R10 overrun cleared", overrun, 0);
    chk("R12 ready again", rts_n, 0);
    rts_en = 1'b0;
    idle(2);
    chk("R12 disabled low", rts_n, 0);
  endtask

  task automatic t_ext();
    bit s, t;
    logic [7:0] pat;
    logic [7:0] txb;
    pat = 8'h4D; txb = 8'h00;
    ext_clk_sel = 1'b1; loop_en = 1'b0;
    idle(3);
    chk("R14 sclk_oe low", sclk_oe, 0);
    pulse_wr(8'hB2);
    idle(4);
    for (int i = 0; i < 8; i++) begin
      sdi_drv = pat[i];
      sclk_i = 1'b0;
      idle(8);
      txb[i] = sdo;
      sclk_i = 1'b1;
      idle(8);
    end
    wait_rx(s, t);
    chk("R14 rx byte", rd_data, 8'h4D);
    chk("R14 tx line", txb, 8'hB2);
    pulse_rd();
    ext_clk_sel = 1'b0; loop_en = 1'b1;
    idle(3);
  endtask

  task automatic t_cont();
    bit s, t;
    int base;
    cont_rx = 1'b1;
    pulse_wr(8'h77);
    wait_rx(s, t);
    chk("R11 first byte", rd_data, 8'h77);
    base = toggles;
    idle(200);
    chk("R11 waits for read", toggles - base, 0);
    pulse_rd();
    wait_rx(s, t);
    chk("R11 read restarts", s, 1);
    chk("R11 same byte", rd_data, 8'h77);
    tx_en = 1'b0; cont_rx = 1'b0;
    pulse_rd();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    idle(3);
    t_divider();
    t_lsb();
    t_msb();
    t_invert();
    t_pol1();
    t_gate();
    t_rx_dis();
    t_txirq();
    t_overrun();
    t_ext();
    t_cont();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule